// File: doc/BRIEF.md
# Coherence Message Merge Channel

This block carries coherence traffic from several child caches toward their shared parent. Each child (source) owns two private queues, one for requests and one for responses. A child can fill or stall either of its queues without touching any other queue. All queues drain onto one physical link toward the parent, which carries a class bit and the source index with every message.

The parent signals readiness separately for each class. A message is offered only for a class whose ready is high, and it counts as transferred in every cycle the output valid is high. Responses always win the link over requests, so a parent that stalls requests can never hold back a response. Responses and requests each have their own round-robin pointer, so no child starves within a class.

A request is held at the head of its queue while a response to the same address is still queued from the same child. An earlier response is therefore never overtaken. The parent must treat responses as always sinkable for the no-stall guarantee to hold.

Top module: `cmsg_merge`

## Requirements
- R1: Every queue holds DEPTH messages; its ready output is low exactly when it is full, and a push offered while full is dropped.
- R2: Messages of one class from one source leave in the order they were pushed, with address and data unaltered.
- R3: When any response is queued and `up_rsp_ready_i` is high, the message offered on the output is a response.
- R4: A low `up_req_ready_i` never holds back queued responses, and a message of a class is offered only while that class's ready input is high.
- R5: A full queue at one source or class leaves the ready outputs of all other queues unchanged.
- R6: A request is not offered while a response with the same address is queued from the same source; a matching response queued at a different source does not hold it.
- R7: Requests are granted round-robin, searching upward from a pointer that moves to the winner plus one only when a request is transferred.
- R8: Responses are granted round-robin with their own pointer, following the same rule as R7.
- R9: After reset all queues are empty, `out_valid_o` is low, every ready output is high, and both pointers select source 0.
- R10: `out_src_o` gives the source index, and `out_is_rsp_o` is 1 for a response and 0 for a request; the message is consumed in each cycle `out_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | N_SRC | Request push per source |
| req_ready_o | output | N_SRC | Request queue not full, per source |
| req_addr_i | input | N_SRC*ADDR_W | Request address per source |
| req_data_i | input | N_SRC*DATA_W | Request payload per source |
| rsp_valid_i | input | N_SRC | Response push per source |
| rsp_ready_o | output | N_SRC | Response queue not full, per source |
| rsp_addr_i | input | N_SRC*ADDR_W | Response address per source |
| rsp_data_i | input | N_SRC*DATA_W | Response payload per source |
| up_req_ready_i | input | 1 | Parent accepts requests |
| up_rsp_ready_i | input | 1 | Parent accepts responses |
| out_valid_o | output | 1 | Message transferred this cycle |
| out_is_rsp_o | output | 1 | Class of the output message |
| out_src_o | output | clog2(N_SRC) | Source index of the output message |
| out_addr_o | output | ADDR_W | Address of the output message |
| out_data_o | output | DATA_W | Payload of the output message |

## Verification
The bench first loads mixed queues while both class readies are low. It then drains them, so response priority and each round-robin pointer are visible in the exact order of sources. A pattern with the same address in a response and a request from one child, plus a request for that address from another child, separates a per-source hazard check from an over-broad global one. Stalling one class ready at a time shows whether the other class still flows. Filling one queue to overflow separates correct drop and isolation from leakage into neighbouring readies or reordered drains.

// File: rtl/cmsg_pkg.sv
package cmsg_pkg;
    typedef enum logic {
        CLS_REQ = 1'b0,
        CLS_RSP = 1'b1
    } msg_class_e;

    function automatic int wrap_inc(input int idx, input int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction
endpackage

// File: rtl/cmsg_fifo.sv
module cmsg_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 push_i,
    input  logic [W-1:0]         push_data_i,
    input  logic                 pop_i,
    output logic                 full_o,
    output logic                 empty_o,
    output logic [W-1:0]         head_o,
    output logic [DEPTH*W-1:0]   slot_data_o,
    output logic [DEPTH-1:0]     slot_valid_o
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rd;
        logic [PW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } fifo_state_t;

    fifo_state_t st_d, st_q;
    logic do_push, do_pop;

    assign full_o  = (st_q.cnt == CW'(DEPTH));
    assign empty_o = (st_q.cnt == '0);
    assign head_o  = st_q.mem[st_q.rd];

    always_comb begin
        st_d    = st_q;
        do_push = push_i && !full_o;
        do_pop  = pop_i && !empty_o;
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data_i;
            st_d.wr           = st_q.wr + 1'b1;
        end
        if (do_pop) begin
            st_d.rd = st_q.rd + 1'b1;
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [PW-1:0] offset;
        assign offset          = PW'(i) - st_q.rd;
        assign slot_valid_o[i] = (CW'(offset) < st_q.cnt);
        assign slot_data_o[i*W +: W] = st_q.mem[i];
    end

    assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    assert_pop_only_nonempty_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/cmsg_rr_arb.sv
module cmsg_rr_arb #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] cand_i,
    input  logic         take_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    import cmsg_pkg::*;
    localparam int IW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        logic [IW-1:0] ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;
    int win_idx;

    always_comb begin
        grant_o = '0;
        win_idx = 0;
        any_o   = 1'b0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = int'(st_q.ptr) + k;
            if (idx >= N) idx = idx - N;
            if (!any_o && cand_i[idx]) begin
                any_o        = 1'b1;
                win_idx      = idx;
                grant_o[idx] = 1'b1;
            end
        end
        st_d = st_q;
        if (take_i && any_o) begin
            st_d.ptr = IW'(wrap_inc(win_idx, N));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_grant_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant_o));

    assert_grant_in_cand_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_o & ~cand_i) == '0);

    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(st_q.ptr));

    assert_take_needs_cand_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (cand_i != '0));
endmodule

// File: rtl/cmsg_merge.sv
module cmsg_merge #(
    parameter int N_SRC  = 4,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [N_SRC-1:0]          req_valid_i,
    output logic [N_SRC-1:0]          req_ready_o,
    input  logic [N_SRC*ADDR_W-1:0]   req_addr_i,
    input  logic [N_SRC*DATA_W-1:0]   req_data_i,
    input  logic [N_SRC-1:0]          rsp_valid_i,
    output logic [N_SRC-1:0]          rsp_ready_o,
    input  logic [N_SRC*ADDR_W-1:0]   rsp_addr_i,
    input  logic [N_SRC*DATA_W-1:0]   rsp_data_i,
    input  logic                      up_req_ready_i,
    input  logic                      up_rsp_ready_i,
    output logic                      out_valid_o,
    output logic                      out_is_rsp_o,
    output logic [$clog2(N_SRC)-1:0]  out_src_o,
    output logic [ADDR_W-1:0]         out_addr_o,
    output logic [DATA_W-1:0]         out_data_o
);
    import cmsg_pkg::*;
    localparam int MW = ADDR_W + DATA_W;
    localparam int SW = $clog2(N_SRC);

    logic [N_SRC-1:0]        req_full, req_empty, rsp_full, rsp_empty;
    logic [N_SRC-1:0]        req_pop, rsp_pop, hazard;
    logic [N_SRC-1:0][MW-1:0] req_head, rsp_head;
    logic [N_SRC-1:0]        req_cand, rsp_cand, req_grant, rsp_grant;
    logic                    req_any, rsp_any, req_take, rsp_take;

    for (genvar s = 0; s < N_SRC; s++) begin : g_src
        logic [DEPTH*MW-1:0] rsp_slots;
        logic [DEPTH-1:0]    rsp_slot_vld;
        logic [DEPTH*MW-1:0] req_slots_unused;
        logic [DEPTH-1:0]    req_vld_unused;
        logic [DEPTH-1:0]    match;

        cmsg_fifo #(.W(MW), .DEPTH(DEPTH)) u_reqq (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (req_valid_i[s]),
            .push_data_i ({req_addr_i[s*ADDR_W +: ADDR_W], req_data_i[s*DATA_W +: DATA_W]}),
            .pop_i       (req_pop[s]),
            .full_o      (req_full[s]),
            .empty_o     (req_empty[s]),
            .head_o      (req_head[s]),
            .slot_data_o (req_slots_unused),
            .slot_valid_o(req_vld_unused)
        );

        cmsg_fifo #(.W(MW), .DEPTH(DEPTH)) u_rspq (
            .clk         (clk),
            .rst_n       (rst_n),
            .push_i      (rsp_valid_i[s]),
            .push_data_i ({rsp_addr_i[s*ADDR_W +: ADDR_W], rsp_data_i[s*DATA_W +: DATA_W]}),
            .pop_i       (rsp_pop[s]),
            .full_o      (rsp_full[s]),
            .empty_o     (rsp_empty[s]),
            .head_o      (rsp_head[s]),
            .slot_data_o (rsp_slots),
            .slot_valid_o(rsp_slot_vld)
        );

        for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
            assign match[i] = rsp_slot_vld[i] &&
                (rsp_slots[i*MW + DATA_W +: ADDR_W] == req_head[s][MW-1:DATA_W]);
        end

        assign hazard[s]      = |match;
        assign req_ready_o[s] = !req_full[s];
        assign rsp_ready_o[s] = !rsp_full[s];
        assign rsp_cand[s]    = !rsp_empty[s] && up_rsp_ready_i;
        assign req_cand[s]    = !req_empty[s] && !hazard[s] && up_req_ready_i;
    end

    assign rsp_take = rsp_any;
    assign req_take = !rsp_any && req_any;
    assign rsp_pop  = rsp_grant & {N_SRC{rsp_take}};
    assign req_pop  = req_grant & {N_SRC{req_take}};

    cmsg_rr_arb #(.N(N_SRC)) u_rsp_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (rsp_cand),
        .take_i (rsp_take),
        .grant_o(rsp_grant),
        .any_o  (rsp_any)
    );

    cmsg_rr_arb #(.N(N_SRC)) u_req_arb (
        .clk    (clk),
        .rst_n  (rst_n),
        .cand_i (req_cand),
        .take_i (req_take),
        .grant_o(req_grant),
        .any_o  (req_any)
    );

    always_comb begin
        logic [MW-1:0]    msg;
        logic [N_SRC-1:0] sel;
        msg          = '0;
        out_src_o    = '0;
        sel          = rsp_any ? rsp_grant : req_grant;
        out_valid_o  = rsp_any || req_any;
        out_is_rsp_o = rsp_any ? CLS_RSP : CLS_REQ;
        for (int s = 0; s < N_SRC; s++) begin
            if (sel[s]) begin
                msg       = rsp_any ? rsp_head[s] : req_head[s];
                out_src_o = SW'(s);
            end
        end
        out_addr_o = msg[MW-1:DATA_W];
        out_data_o = msg[DATA_W-1:0];
    end

    assert_rsp_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid_o && !out_is_rsp_o) |-> !(up_rsp_ready_i && !(&rsp_empty)));

    assert_class_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (out_is_rsp_o ? up_rsp_ready_i : up_req_ready_i));

    assert_pop_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({req_pop, rsp_pop}) == (out_valid_o ? 1 : 0));
endmodule

// File: tb/cmsg_merge_tb.sv
module cmsg_merge_tb;
    localparam int N  = 4;
    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NV = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    req_valid, rsp_valid, req_ready, rsp_ready;
    logic [N*AW-1:0] req_addr, rsp_addr;
    logic [N*DW-1:0] req_data, rsp_data;
    logic up_req_ready, up_rsp_ready;
    logic out_valid, out_is_rsp;
    logic [1:0] out_src;
    logic [AW-1:0] out_addr;
    logic [DW-1:0] out_data;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    cmsg_merge #(.N_SRC(N), .ADDR_W(AW), .DATA_W(DW), .DEPTH(4)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready),
        .req_addr_i(req_addr), .req_data_i(req_data),
        .rsp_valid_i(rsp_valid), .rsp_ready_o(rsp_ready),
        .rsp_addr_i(rsp_addr), .rsp_data_i(rsp_data),
        .up_req_ready_i(up_req_ready), .up_rsp_ready_i(up_rsp_ready),
        .out_valid_o(out_valid), .out_is_rsp_o(out_is_rsp),
        .out_src_o(out_src), .out_addr_o(out_addr), .out_data_o(out_data)
    );

    // {push, push_is_rsp, push_src, push_addr, rsp_rdy, req_rdy, exp_valid, exp_is_rsp, exp_src, exp_addr}
    localparam logic [25:0] VEC [NV] = '{
        {1'b1,1'b0,2'd0,8'd10, 1'b0,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b0,2'd0,8'd11, 1'b0,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b0,2'd1,8'd20, 1'b0,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b0,2'd2,8'd30, 1'b0,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b1,2'd3,8'd40, 1'b0,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b1,2'd1,8'd50, 1'b0,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b1,2'd1,8'd50}, // R3 R8
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b1,2'd3,8'd40}, // R8
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b0,2'd0,8'd10}, // R7
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b0,2'd1,8'd20}, // R7
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b0,2'd2,8'd30}, // R7
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b0,2'd0,8'd11}, // R2 R7
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b1,2'd2,8'd77, 1'b0,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b0,2'd2,8'd77, 1'b0,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b0,2'd1,8'd77, 1'b0,1'b1, 1'b0,1'b0,2'd0,8'd0},  // R6 held
        {1'b0,1'b0,2'd0,8'd0,  1'b0,1'b1, 1'b1,1'b0,2'd1,8'd77}, // R6 other source
        {1'b0,1'b0,2'd0,8'd0,  1'b0,1'b1, 1'b0,1'b0,2'd0,8'd0},  // R6 still held
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b0, 1'b1,1'b1,2'd2,8'd77}, // R4
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b0,2'd2,8'd77}, // R6 released
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b0,2'd0,8'd5,  1'b0,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b1,2'd0,8'd6,  1'b0,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b1,2'd0,8'd6},  // R3
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b0,2'd0,8'd5},
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b0,1'b0,2'd0,8'd0},
        {1'b1,1'b0,2'd0,8'd1,  1'b1,1'b0, 1'b0,1'b0,2'd0,8'd0},  // R4 gate
        {1'b1,1'b0,2'd3,8'd3,  1'b1,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b0, 1'b0,1'b0,2'd0,8'd0},
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b0,2'd3,8'd3},  // R7 pointer kept
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b1,1'b0,2'd0,8'd1},
        {1'b0,1'b0,2'd0,8'd0,  1'b1,1'b1, 1'b0,1'b0,2'd0,8'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        req_valid = '0; rsp_valid = '0;
        req_addr = '0; rsp_addr = '0; req_data = '0; rsp_data = '0;
    endtask

    task automatic set_push(input logic is_rsp, input int src, input logic [7:0] a);
        if (is_rsp) begin
            rsp_valid[src] = 1'b1;
            rsp_addr[src*AW +: AW] = a;
            rsp_data[src*DW +: DW] = a ^ 8'hA5;
        end else begin
            req_valid[src] = 1'b1;
            req_addr[src*AW +: AW] = a;
            req_data[src*DW +: DW] = a ^ 8'hA5;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        up_req_ready = 1'b0; up_rsp_ready = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic expect_out(input string tag, input logic [1:0] src, input logic [7:0] a);
        check({tag, " valid"}, 32'(out_valid), 32'd1);
        check({tag, " src"}, 32'(out_src), 32'(src));
        check({tag, " addr"}, 32'(out_addr), 32'(a));
        check({tag, " data"}, 32'(out_data), 32'(a ^ 8'hA5));
    endtask

    initial begin
        idle_inputs();
        up_req_ready = 1'b0; up_rsp_ready = 1'b0;
        do_reset();

        // R9: reset state
        #1;
        check("R9 out_valid", 32'(out_valid), 32'd0);
        check("R9 req_ready", 32'(req_ready), 32'hF);
        check("R9 rsp_ready", 32'(rsp_ready), 32'hF);

        for (int v = 0; v < NV; v++) begin
            logic [25:0] e;
            e = VEC[v];
            @(negedge clk);
            idle_inputs();
            if (e[25]) set_push(e[24], int'(e[23:22]), e[21:14]);
            up_rsp_ready = e[13];
            up_req_ready = e[12];
            #1;
            check($sformatf("R6 vec%0d valid", v), 32'(out_valid), 32'(e[11]));
            if (e[11]) begin
                check($sformatf("R3 R10 vec%0d class", v), 32'(out_is_rsp), 32'(e[10]));
                check($sformatf("R7 R8 R10 vec%0d src", v), 32'(out_src), 32'(e[9:8]));
                check($sformatf("R2 vec%0d addr", v), 32'(out_addr), 32'(e[7:0]));
                check($sformatf("R2 vec%0d data", v), 32'(out_data), 32'(e[7:0] ^ 8'hA5));
            end
        end

        // R1 R5: fill source 1 requests, then push once more while full
        do_reset();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            idle_inputs();
            set_push(1'b0, 1, (k == 4) ? 8'h99 : 8'(8'h60 + k));
        end
        @(negedge clk);
        idle_inputs();
        #1;
        check("R1 full ready low", 32'(req_ready[1]), 32'd0);
        check("R5 other req ready", 32'(req_ready & 4'b1101), 32'hD);
        check("R5 rsp ready", 32'(rsp_ready), 32'hF);
        up_req_ready = 1'b1;
        for (int k = 0; k < 4; k++) begin
            #1;
            expect_out("R2 drain", 2'd1, 8'(8'h60 + k));
            @(negedge clk);
        end
        #1;
        check("R1 dropped push", 32'(out_valid), 32'd0);

        // R9 R7: pointer at source 0 after reset
        do_reset();
        @(negedge clk);
        idle_inputs();
        set_push(1'b0, 2, 8'h70);
        set_push(1'b0, 1, 8'h71);
        @(negedge clk);
        idle_inputs();
        up_req_ready = 1'b1;
        #1;
        expect_out("R9 ptr", 2'd1, 8'h71);
        @(negedge clk);
        #1;
        expect_out("R7 next", 2'd2, 8'h70);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #400000;
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule